// File: doc/BRIEF.md
# Keyed Four-Word Flash Block Writer

This block sits between a CPU's register write bus and a behavioural model of the program flash array. Software first loads a destination word address and a 14-bit data word into byte-wide registers. It then writes a two-byte unlock key and sets a start bit. Each start that follows a complete key places the word into one entry of a four-entry staging buffer. The entry is chosen by the two low address bits.

Starts aimed at the first three words of an aligned four-word group finish after a short setup window, and the flash is not touched. A start aimed at the fourth word, whose low address bits are 11, does more. It erases the whole group, then holds the CPU stalled for a programmable number of cycles, then writes all four buffer entries into the group in one step. Clocks keep running during the stall.

A 2-bit write-protect setting masks off part of the array. A start that lands in the protected part runs its setup window and does nothing else. A combinational read port lets the surrounding logic see the array contents.

Top module: `flash_blk_writer`

## Requirements
- R1: After reset, `wrStart` and `cpuStall` are low, the unlock tracker holds no progress, and every flash word and every staging entry reads 3FFFh.
- R2: A write starts only when three consecutive bus writes are: key register (select 5) with 55h, key register with AAh, then control register (select 4) with bit 1 set. Any other bus write resets the unlock progress, except that a 55h written to the key register always counts as the first step. A start that has no completed key leaves `wrStart` low and the flash unchanged.
- R3: The start write must also have bit 7 of the control register set, which selects program memory. With bit 7 clear, the start is ignored and the unlock progress is still used up.
- R4: Registers are chosen by `busSel`: 0 holds address bits 7:0, 1 holds address bits ADDR_W-1:8 (from the low bits of the byte), 2 holds data bits 7:0, and 3 holds data bits 13:8 (from byte bits 5:0, with bits 7:6 dropped). Selects 6 and 7 store nothing.
- R5: A start whose address has low bits 00, 01 or 10 raises `wrStart` for exactly SETUP_CYCLES cycles. It never raises `cpuStall`, leaves the flash unchanged, and stores the word in the staging entry chosen by those bits.
- R6: A start whose address has low bits 11 first stores the word and runs the SETUP_CYCLES setup window. It then reads 3FFFh from all four group words for exactly PROG_CYCLES cycles with `cpuStall` high. After that the group holds the four staging entries, including entries left over from earlier groups, and `wrStart` and `cpuStall` fall together.
- R7: `wpCfg` selects the protected range: 0 protects nothing, 1 the top quarter of the word space, 2 the top half, and 3 the whole array. A start whose group lies in the protected range holds `wrStart` for SETUP_CYCLES cycles and changes neither the flash nor the staging buffer.
- R8: While `wrStart` is high, bus writes change no register and do not touch the unlock tracker.
- R9: `flashRdData` shows the array word at `flashRdAddr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busSel | input | 3 | Register select |
| busWdata | input | 8 | Register write byte |
| wpCfg | input | 2 | Write-protect range setting |
| flashRdAddr | input | ADDR_W | Array read address |
| flashRdData | output | 14 | Array word at the read address |
| wrStart | output | 1 | Start bit; high from an honoured start until the operation ends |
| cpuStall | output | 1 | CPU halt request during erase and program |

## Verification
The bench goes after the unlock corners. These are a key broken by an unrelated write, a reversed key, a repeated 55h, a start with the memory-select bit clear, and keys written while the block is busy. A tracker that is too forgiving would raise `wrStart` on one of these. A tracker that is too strict would miss the repeated-55h start.

The bench also writes only the last word of a group and checks that stale staging entries are programmed. A design that cleared the buffer, or that wrote only the addressed word, would leave 3FFFh or old data in that group. Protected starts are followed by an unprotected partial group. This exposes a design that loads the buffer on a refused write. The stall length, the erase window and the setup length are compared cycle by cycle, so an off-by-one counter shows up at once.

// File: rtl/fbw_pkg.sv
package fbw_pkg;
  localparam int WORD_W = 14;
  localparam int HI_DATA_W = WORD_W - 8;

  localparam logic [2:0] SEL_ADDR_LO = 3'd0;
  localparam logic [2:0] SEL_ADDR_HI = 3'd1;
  localparam logic [2:0] SEL_DATA_LO = 3'd2;
  localparam logic [2:0] SEL_DATA_HI = 3'd3;
  localparam logic [2:0] SEL_CTRL    = 3'd4;
  localparam logic [2:0] SEL_KEY     = 3'd5;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  localparam int CTRL_START_BIT  = 1;
  localparam int CTRL_MEMSEL_BIT = 7;

  localparam logic [WORD_W-1:0] ERASED_WORD = '1;

  typedef enum logic [1:0] {
    KEY_IDLE,
    KEY_HALF,
    KEY_ARMED
  } keyState_t;

  typedef enum logic [1:0] {
    OP_IDLE,
    OP_SETUP,
    OP_PROG
  } opState_t;

  typedef struct packed {
    logic regLock;
    logic loadBuf;
    logic eraseGrp;
    logic progGrp;
  } dpStrobe_t;
endpackage

// File: rtl/fbw_ctrl.sv
module fbw_ctrl
  import fbw_pkg::*;
#(
  parameter int SETUP_CYCLES = 2,
  parameter int PROG_CYCLES  = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWr,
  input  logic [2:0] busSel,
  input  logic [7:0] busWdata,
  input  logic [1:0] addrLowBits,
  input  logic       grpProtected,
  output dpStrobe_t  strobe,
  output logic       wrStart,
  output logic       cpuStall
);
  localparam int CNT_MAX = (SETUP_CYCLES > PROG_CYCLES) ? SETUP_CYCLES : PROG_CYCLES;
  localparam int CNT_W = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYCLES - 1);
  localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYCLES - 1);

  keyState_t keyQ, keyNext;
  opState_t  opQ;
  logic [CNT_W-1:0] cntQ;
  logic lastQ, protQ;
  logic startOk, setupDone, progDone;

  // unlock tracker: any accepted write that is not the next key step clears progress
  always_comb begin
    keyNext = keyQ;
    if (busWr && opQ == OP_IDLE) begin
      if (busSel == SEL_KEY && busWdata == KEY_FIRST) begin
        keyNext = KEY_HALF;
      end else if (busSel == SEL_KEY && busWdata == KEY_SECOND && keyQ == KEY_HALF) begin
        keyNext = KEY_ARMED;
      end else begin
        keyNext = KEY_IDLE;
      end
    end
  end

  assign startOk = busWr && (opQ == OP_IDLE) && (busSel == SEL_CTRL)
                   && busWdata[CTRL_START_BIT] && busWdata[CTRL_MEMSEL_BIT]
                   && (keyQ == KEY_ARMED);

  assign setupDone = (opQ == OP_SETUP) && (cntQ == SETUP_LAST);
  assign progDone  = (opQ == OP_PROG) && (cntQ == PROG_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyQ  <= KEY_IDLE;
      opQ   <= OP_IDLE;
      cntQ  <= '0;
      lastQ <= 1'b0;
      protQ <= 1'b0;
    end else begin
      keyQ <= keyNext;
      unique case (opQ)
        OP_IDLE: begin
          if (startOk) begin
            opQ   <= OP_SETUP;
            cntQ  <= '0;
            lastQ <= (addrLowBits == 2'b11);
            protQ <= grpProtected;
          end
        end
        OP_SETUP: begin
          if (setupDone) begin
            cntQ <= '0;
            opQ  <= (!protQ && lastQ) ? OP_PROG : OP_IDLE;
          end else begin
            cntQ <= cntQ + 1'b1;
          end
        end
        OP_PROG: begin
          if (progDone) begin
            cntQ <= '0;
            opQ  <= OP_IDLE;
          end else begin
            cntQ <= cntQ + 1'b1;
          end
        end
        default: opQ <= OP_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.regLock  = (opQ != OP_IDLE);
    strobe.loadBuf  = setupDone && !protQ;
    strobe.eraseGrp = setupDone && !protQ && lastQ;
    strobe.progGrp  = progDone;
  end

  assign wrStart  = (opQ != OP_IDLE);
  assign cpuStall = (opQ == OP_PROG);
endmodule

// File: rtl/fbw_dpath.sv
module fbw_dpath
  import fbw_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [2:0]        busSel,
  input  logic [7:0]        busWdata,
  input  logic [1:0]        wpCfg,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] flashRdAddr,
  output logic [WORD_W-1:0] flashRdData,
  output logic [1:0]        addrLowBits,
  output logic              grpProtected
);
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int HI_W      = ADDR_W - 8;
  localparam int GRP_WORDS = 4;
  localparam int LIM_W     = ADDR_W + 1;
  localparam logic [LIM_W-1:0] LIM_NONE    = LIM_W'(DEPTH);
  localparam logic [LIM_W-1:0] LIM_QUARTER = LIM_W'(DEPTH - DEPTH / 4);
  localparam logic [LIM_W-1:0] LIM_HALF    = LIM_W'(DEPTH / 2);

  logic [7:0]           addrLoQ;
  logic [HI_W-1:0]      addrHiQ;
  logic [7:0]           dataLoQ;
  logic [HI_DATA_W-1:0] dataHiQ;
  logic [WORD_W-1:0]    bufQ [GRP_WORDS];
  logic [WORD_W-1:0]    mem  [DEPTH];

  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-3:0] grpIdx;
  logic [LIM_W-1:0]  protLimit;
  logic              regWrOk;

  assign curAddr = {addrHiQ, addrLoQ};
  assign grpIdx  = curAddr[ADDR_W-1:2];
  assign addrLowBits = curAddr[1:0];
  assign regWrOk = busWr && !strobe.regLock;

  always_comb begin
    unique case (wpCfg)
      2'd0:    protLimit = LIM_NONE;
      2'd1:    protLimit = LIM_QUARTER;
      2'd2:    protLimit = LIM_HALF;
      default: protLimit = '0;
    endcase
  end

  assign grpProtected = ({1'b0, grpIdx, 2'b00} >= protLimit);

  // address and data holding registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrLoQ <= '0;
      addrHiQ <= '0;
      dataLoQ <= '0;
      dataHiQ <= '0;
    end else if (regWrOk) begin
      unique case (busSel)
        SEL_ADDR_LO: addrLoQ <= busWdata;
        SEL_ADDR_HI: addrHiQ <= busWdata[HI_W-1:0];
        SEL_DATA_LO: dataLoQ <= busWdata;
        SEL_DATA_HI: dataHiQ <= busWdata[HI_DATA_W-1:0];
        default: ;
      endcase
    end
  end

  // staging buffer, one entry per word of the group
  generate
    for (genvar e = 0; e < GRP_WORDS; e++) begin : g_buf
      always_ff @(posedge clk) begin
        if (!rstN) begin
          bufQ[e] <= ERASED_WORD;
        end else if (strobe.loadBuf && curAddr[1:0] == 2'(e)) begin
          bufQ[e] <= {dataHiQ, dataLoQ};
        end
      end
    end
  endgenerate

  // behavioural flash array: erase at the start of programming, copy at the end
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int a = 0; a < DEPTH; a++) begin
        mem[a] <= ERASED_WORD;
      end
    end else if (strobe.eraseGrp) begin
      for (int w = 0; w < GRP_WORDS; w++) begin
        mem[{grpIdx, 2'(w)}] <= ERASED_WORD;
      end
    end else if (strobe.progGrp) begin
      for (int w = 0; w < GRP_WORDS; w++) begin
        mem[{grpIdx, 2'(w)}] <= bufQ[w];
      end
    end
  end

  assign flashRdData = mem[flashRdAddr];
endmodule

// File: rtl/flash_blk_writer.sv
module flash_blk_writer
  import fbw_pkg::*;
#(
  parameter int ADDR_W       = 9,
  parameter int SETUP_CYCLES = 2,
  parameter int PROG_CYCLES  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [2:0]        busSel,
  input  logic [7:0]        busWdata,
  input  logic [1:0]        wpCfg,
  input  logic [ADDR_W-1:0] flashRdAddr,
  output logic [13:0]       flashRdData,
  output logic              wrStart,
  output logic              cpuStall
);
  dpStrobe_t strobe;
  logic [1:0] addrLowBits;
  logic grpProtected;

  fbw_ctrl #(
    .SETUP_CYCLES(SETUP_CYCLES),
    .PROG_CYCLES (PROG_CYCLES)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .busWr       (busWr),
    .busSel      (busSel),
    .busWdata    (busWdata),
    .addrLowBits (addrLowBits),
    .grpProtected(grpProtected),
    .strobe      (strobe),
    .wrStart     (wrStart),
    .cpuStall    (cpuStall)
  );

  fbw_dpath #(
    .ADDR_W(ADDR_W)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .busWr       (busWr),
    .busSel      (busSel),
    .busWdata    (busWdata),
    .wpCfg       (wpCfg),
    .strobe      (strobe),
    .flashRdAddr (flashRdAddr),
    .flashRdData (flashRdData),
    .addrLowBits (addrLowBits),
    .grpProtected(grpProtected)
  );
endmodule

// File: rtl/fbw_checks.sv
module fbw_checks
  import fbw_pkg::*;
#(
  parameter int ADDR_W       = 9,
  parameter int SETUP_CYCLES = 2,
  parameter int PROG_CYCLES  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic [2:0]        busSel,
  input logic [7:0]        busWdata,
  input logic [ADDR_W-1:0] flashRdAddr,
  input logic [13:0]       flashRdData,
  input logic              wrStart,
  input logic              cpuStall
);
  logic [10:0] hist1, hist2, hist3;
  int stallCnt, setupCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hist1 <= '0;
      hist2 <= '0;
      hist3 <= '0;
      stallCnt <= 0;
      setupCnt <= 0;
    end else begin
      if (busWr) begin
        hist3 <= hist2;
        hist2 <= hist1;
        hist1 <= {busSel, busWdata};
      end
      stallCnt <= cpuStall ? stallCnt + 1 : 0;
      setupCnt <= (wrStart && !cpuStall) ? setupCnt + 1 : 0;
    end
  end

  AST_START_FOLLOWS_KEY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrStart) |-> (hist2 == {SEL_KEY, KEY_SECOND}) && (hist3 == {SEL_KEY, KEY_FIRST})); // R2
  AST_START_NEEDS_MEMSEL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrStart) |-> $past(busWr && busSel == SEL_CTRL && busWdata[CTRL_MEMSEL_BIT] && busWdata[CTRL_START_BIT])); // R3
  AST_SETUP_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(wrStart) && !$past(cpuStall)) || $rose(cpuStall) |-> $past(setupCnt) == SETUP_CYCLES - 1); // R5
  AST_STALL_INSIDE_START: assert property (@(posedge clk) disable iff (!rstN)
    cpuStall |-> wrStart); // R6
  AST_STALL_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    cpuStall |-> stallCnt < PROG_CYCLES); // R6
  AST_STALL_FULL_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuStall) |-> ($past(stallCnt) == PROG_CYCLES - 1) && !wrStart); // R6
  AST_FLASH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $stable(flashRdAddr) && !cpuStall && !$past(cpuStall) |-> $stable(flashRdData)); // R5
endmodule

bind flash_blk_writer fbw_checks #(
  .ADDR_W      (ADDR_W),
  .SETUP_CYCLES(SETUP_CYCLES),
  .PROG_CYCLES (PROG_CYCLES)
) u_fbw_checks (
  .clk        (clk),
  .rstN       (rstN),
  .busWr      (busWr),
  .busSel     (busSel),
  .busWdata   (busWdata),
  .flashRdAddr(flashRdAddr),
  .flashRdData(flashRdData),
  .wrStart    (wrStart),
  .cpuStall   (cpuStall)
);

// File: tb/test_flash_blk_writer.sv
`timescale 1ns/1ps
module test_flash_blk_writer;
  localparam int ADDR_W = 9;
  localparam int SETUP  = 2;
  localparam int PROG   = 24;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0;
  logic [2:0] busSel = 3'd0;
  logic [7:0] busWdata = 8'd0;
  logic [1:0] wpCfg = 2'd0;
  logic [ADDR_W-1:0] flashRdAddr = '0;
  logic [13:0] flashRdData;
  logic wrStart, cpuStall;

  int tests = 0;
  int fails = 0;

  flash_blk_writer #(.ADDR_W(ADDR_W), .SETUP_CYCLES(SETUP), .PROG_CYCLES(PROG)) i_flash_blk_writer (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busSel(busSel), .busWdata(busWdata),
    .wpCfg(wpCfg), .flashRdAddr(flashRdAddr), .flashRdData(flashRdData),
    .wrStart(wrStart), .cpuStall(cpuStall)
  );

  always #2.5 clk = ~clk;

  // behavioural reference model
  int mKey, mPhase, mCnt, mAddr, mDLo, mDHi;
  int mBuf[4];
  int mMem[DEPTH];
  bit mLast, mProt, mDoStart;

  function automatic int protLimit(input int cfg);
    case (cfg)
      0: return DEPTH;
      1: return DEPTH - DEPTH / 4;
      2: return DEPTH / 2;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mKey = 0; mPhase = 0; mCnt = 0; mAddr = 0; mDLo = 0; mDHi = 0;
      foreach (mBuf[i]) mBuf[i] = 'h3FFF;
      foreach (mMem[i]) mMem[i] = 'h3FFF;
    end else if (mPhase == 0) begin
      if (busWr) begin
        mDoStart = (busSel == 3'd4) && busWdata[1] && busWdata[7] && (mKey == 2);
        case (busSel)
          3'd0: mAddr = (mAddr & 'h100) | int'(busWdata);
          3'd1: mAddr = (mAddr & 'hFF) | ((int'(busWdata) & 1) << 8);
          3'd2: mDLo = int'(busWdata);
          3'd3: mDHi = int'(busWdata) & 'h3F;
          default: ;
        endcase
        if (busSel == 3'd5 && busWdata == 8'h55) mKey = 1;
        else if (busSel == 3'd5 && busWdata == 8'hAA && mKey == 1) mKey = 2;
        else mKey = 0;
        if (mDoStart) begin
          mPhase = 1; mCnt = 0;
          mLast = ((mAddr & 3) == 3);
          mProt = ((mAddr & ~3) >= protLimit(int'(wpCfg)));
        end
      end
    end else if (mPhase == 1) begin
      mCnt++;
      if (mCnt == SETUP) begin
        mPhase = 0;
        if (!mProt) begin
          mBuf[mAddr & 3] = (mDHi << 8) | mDLo;
          if (mLast) begin
            for (int w = 0; w < 4; w++) mMem[(mAddr & ~3) + w] = 'h3FFF;
            mPhase = 2; mCnt = 0;
          end
        end
      end
    end else begin
      mCnt++;
      if (mCnt == PROG) begin
        for (int w = 0; w < 4; w++) mMem[(mAddr & ~3) + w] = mBuf[w];
        mPhase = 0;
      end
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      tests++;
      if (wrStart !== (mPhase != 0)) begin
        fails++;
        $display("FAIL R5 R6 wrStart: actual %0b expected %0b", wrStart, mPhase != 0);
      end
      tests++;
      if (cpuStall !== (mPhase == 2)) begin
        fails++;
        $display("FAIL R6 cpuStall: actual %0b expected %0b", cpuStall, mPhase == 2);
      end
      tests++;
      if (int'(flashRdData) != mMem[int'(flashRdAddr)]) begin
        fails++;
        $display("FAIL R9 flash[%0h]: actual %0h expected %0h", flashRdAddr, flashRdData, mMem[int'(flashRdAddr)]);
      end
    end
  end

  task automatic bw(input int sel, input int data);
    busWr = 1'b1; busSel = 3'(sel); busWdata = 8'(data);
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  task automatic loadWord(input int addr, input int word);
    bw(0, addr & 'hFF);
    bw(1, addr >> 8);
    bw(2, word & 'hFF);
    bw(3, ((word >> 8) & 'h3F) | 'hC0);
  endtask

  task automatic keyStart();
    bw(5, 'h55);
    bw(5, 'hAA);
    bw(4, 'h82);
  endtask

  task automatic waitIdle(input int grp);
    int n = 0;
    while (wrStart) begin
      flashRdAddr = ADDR_W'(grp + (n % 4));
      n++;
      @(posedge clk); #1;
    end
  endtask

  task automatic checkWord(input int addr, input int expv, input string tag);
    flashRdAddr = ADDR_W'(addr);
    @(negedge clk);
    tests++;
    if (int'(flashRdData) != expv) begin
      fails++;
      $display("FAIL %s word %0h: actual %0h expected %0h", tag, addr, flashRdData, expv);
    end
    @(posedge clk); #1;
  endtask

  task automatic checkIdle(input string tag);
    tests++;
    if (wrStart !== 1'b0 || cpuStall !== 1'b0) begin
      fails++;
      $display("FAIL %s start/stall: actual %0b%0b expected 00", tag, wrStart, cpuStall);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
    checkIdle("R1");
    checkWord(0, 'h3FFF, "R1");
    checkWord(DEPTH - 1, 'h3FFF, "R1");

    // full group at 0x10, with junk in the high data bits (R4 masking)
    loadWord('h10, 'h0123); keyStart(); waitIdle('h10);
    loadWord('h11, 'h2345); keyStart(); waitIdle('h10);
    loadWord('h12, 'h1ABC); keyStart(); waitIdle('h10);
    checkWord('h12, 'h3FFF, "R5");
    loadWord('h13, 'h3F00); keyStart(); waitIdle('h10);
    checkWord('h10, 'h0123, "R6");
    checkWord('h11, 'h2345, "R4");
    checkWord('h13, 'h3F00, "R6");

    // broken keys: interleaved write, reversed order, missing key
    loadWord('h20, 'h0555);
    bw(5, 'h55); bw(6, 'h00); bw(5, 'hAA); bw(4, 'h82);
    checkIdle("R2 interleaved");
    bw(5, 'hAA); bw(5, 'h55); bw(4, 'h82);
    checkIdle("R2 reversed");
    bw(4, 'h82);
    checkIdle("R2 no key");
    // memory-select clear consumes the key
    bw(5, 'h55); bw(5, 'hAA); bw(4, 'h02);
    checkIdle("R3 memsel clear");
    bw(4, 'h82);
    checkIdle("R3 key consumed");
    // repeated 55h still arms
    bw(5, 'h55); bw(5, 'h55); bw(5, 'hAA); bw(4, 'h82);
    tests++;
    if (wrStart !== 1'b1) begin
      fails++;
      $display("FAIL R2 repeated first key: actual %0b expected 1", wrStart);
    end
    waitIdle('h20);

    // last word only: stale entries 01,10 reused; busy writes ignored
    loadWord('h23, 'h0777); keyStart();
    bw(0, 'h00); bw(2, 'h00);
    repeat (3) @(posedge clk);
    #0 bw(5, 'h55); bw(5, 'hAA);
    waitIdle('h20);
    bw(4, 'h82);
    checkIdle("R8 key during busy");
    checkWord('h20, 'h0555, "R6 stale");
    checkWord('h21, 'h2345, "R6 stale");
    checkWord('h23, 'h0777, "R8 addr kept");

    // protected top quarter
    wpCfg = 2'd1;
    for (int w = 0; w < 4; w++) begin
      loadWord('h180 + w, 'h0100 + w); keyStart(); waitIdle('h180);
    end
    checkWord('h183, 'h3FFF, "R7");
    wpCfg = 2'd0;
    loadWord('h187, 'h0042); keyStart(); waitIdle('h184);
    checkWord('h184, 'h0555, "R7 buffer untouched");
    checkWord('h187, 'h0042, "R7");
    // whole array protected
    wpCfg = 2'd3;
    loadWord('h07, 'h1111); keyStart(); waitIdle('h04);
    checkWord('h07, 'h3FFF, "R7 all");
    wpCfg = 2'd0;

    repeat (4) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule